// File: doc/BRIEF.md
# I2S Slave Serial Transmitter with Underrun Detection

This block is the transmit side of an audio serial port running as a bus slave. An external master drives the bit clock and the word-select line. The block moves 16-bit words from a single holding register into a shift register and sends them MSB first on the data line. The data line changes on falling bit-clock edges. The MSB of each slot is sent one bit clock after the word-select transition, as in the standard I2S format. The bit clock and word select are brought into the system clock domain through flop synchronizers. Edges are detected there, so the block runs entirely on the system clock.

Software keeps the stream going by writing the next word before the current one finishes shifting. If the holding register is still empty at the start of a slot, the block raises a sticky underrun flag and sends a filler word instead. An interrupt is raised when underrun reporting is enabled. Transmission then resumes only at a left-channel slot, so the stereo pairing stays intact. A busy flag shows when a written word is still leaving the shifter. Software can safely drop the enable once the empty flag is 1 and the busy flag is 0.

Top module: `i2s_slave_tx`

## Requirements
- R1: After reset: `txe_o`=1, `udr_o`=0, `bsy_o`=0, `irq_o`=0 and `sd_o`=0.
- R2: A write through `wr_en_i` clears `txe_o` in the next cycle. `txe_o` returns to 1 when the held word moves into the shifter.
- R3: A slot begins at the first rising bit-clock edge after a word-select transition. Word select low marks a left slot and high marks a right slot. On the next falling edge the word's MSB is driven. The remaining bits follow on successive falling edges, so a receiver sampling on rising edges 1..16 of the slot sees the word MSB first.
- R4: Words written before each slot start are sent in consecutive slots, in the order they were written.
- R5: Once transmission has started, an empty holding register at the first falling edge of a slot sets `udr_o`. That slot then carries a filler word: the previous word with the default fill mode, zeros with the other fill mode.
- R6: `udr_o` stays set until a `stat_rd_i` pulse clears it. The pulse takes effect one cycle later.
- R7: `irq_o` is 1 exactly when `udr_o` is 1 and `err_ie_i` is 1.
- R8: After an underrun, and at the first start after enable, a held word is loaded only at a left slot. A word written before a right slot waits there, and `txe_o` stays 0.
- R9: `bsy_o` rises when a written word is loaded. It falls on the falling edge that ends that word's LSB unless another written word is loaded there. Filler words never set it, and CPU writes never change it.
- R10: With `en_i` low, `sd_o` and `bsy_o` are 0, nothing is loaded and no underrun is raised. When the last word has been sent, `txe_o`=1 and `bsy_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Transmitter enable |
| err_ie_i | input | 1 | Underrun interrupt enable |
| sck_i | input | 1 | Bit clock from external master |
| ws_i | input | 1 | Word select from external master (0 = left) |
| sd_o | output | 1 | Serial data out |
| wr_en_i | input | 1 | Holding register write strobe |
| wr_data_i | input | DATA_W | Word to transmit |
| stat_rd_i | input | 1 | Status read strobe, clears underrun flag |
| txe_o | output | 1 | Holding register empty |
| udr_o | output | 1 | Sticky underrun flag |
| bsy_o | output | 1 | Written word still in the shifter |
| irq_o | output | 1 | Error interrupt |

## Verification
The bench builds the block with DATA_W=16, SYNC_STAGES=2 and the repeat fill mode. It drives 16 bit clocks per slot, so each slot boundary falls exactly on the edge after the previous LSB. This exercises the back-to-back load path, where `bsy_o` must stay high, and makes each underrun slot replay the last written word. A slow bit clock of 16 system cycles leaves margin for the synchronizer latency. That lets a word written in mid-slot be judged for the next slot boundary. The same timing lets the bench check the left-slot restart after an underrun, writes made while disabled, and the masked interrupt.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  typedef enum logic {
    FILL_ZERO   = 1'b0,
    FILL_REPEAT = 1'b1
  } fill_mode_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_ev_t;
endpackage

// File: rtl/i2s_edge_sync.sv
module i2s_edge_sync
  import i2s_tx_pkg::*;
#(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     din_i,
  output edge_ev_t ev_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign ev_o.rise = sync_q[STAGES-1] & ~prev_q;
  assign ev_o.fall = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/i2s_tx_hold.sv
module i2s_tx_hold #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              take_i,
  output logic [DATA_W-1:0] word_o,
  output logic              txe_o
);
  logic [DATA_W-1:0] data_q;
  logic              empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      empty_q <= 1'b1;
    end else if (wr_i) begin
      data_q  <= wdata_i;
      empty_q <= 1'b0;
    end else if (take_i) begin
      empty_q <= 1'b1;
    end
  end

  assign word_o = data_q;
  assign txe_o  = empty_q;
endmodule

// File: rtl/i2s_tx_shift.sv
module i2s_tx_shift
  import i2s_tx_pkg::*;
#(
  parameter int         DATA_W = 16,
  parameter fill_mode_e FILL   = FILL_REPEAT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic              load_real_i,
  input  logic              load_fill_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              sd_o,
  output logic              bsy_o
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sh_q, fill_w, next_w;
  logic [CNT_W-1:0]  cnt_q;
  logic              sd_q, bsy_q;

  generate
    if (FILL == FILL_REPEAT) begin : g_repeat
      logic [DATA_W-1:0] last_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          last_q <= '0;
        else if (clr_i)       last_q <= '0;
        else if (load_real_i) last_q <= word_i;
      end
      assign fill_w = last_q;
    end else begin : g_zero
      assign fill_w = '0;
    end
  endgenerate

  assign next_w = load_real_i ? word_i : fill_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      sd_q  <= 1'b0;
      bsy_q <= 1'b0;
    end else if (clr_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
      sd_q  <= 1'b0;
      bsy_q <= 1'b0;
    end else if (step_i) begin
      if (load_real_i || load_fill_i) begin
        sd_q  <= next_w[DATA_W-1];
        sh_q  <= {next_w[DATA_W-2:0], 1'b0};
        cnt_q <= CNT_W'(DATA_W - 1);
        bsy_q <= load_real_i;
      end else if (cnt_q != '0) begin
        sd_q  <= sh_q[DATA_W-1];
        sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
        cnt_q <= cnt_q - 1'b1;
      end else begin
        // LSB period over: word has left the shifter
        sd_q  <= 1'b0;
        bsy_q <= 1'b0;
      end
    end
  end

  assign sd_o  = sd_q;
  assign bsy_o = bsy_q;
endmodule

// File: rtl/i2s_slave_tx.sv
module i2s_slave_tx
  import i2s_tx_pkg::*;
#(
  parameter int         DATA_W      = 16,
  parameter int         SYNC_STAGES = 2,
  parameter fill_mode_e FILL        = FILL_REPEAT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              err_ie_i,
  input  logic              sck_i,
  input  logic              ws_i,
  output logic              sd_o,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              stat_rd_i,
  output logic              txe_o,
  output logic              udr_o,
  output logic              bsy_o,
  output logic              irq_o
);
  edge_ev_t          sck_ev, ws_ev;
  logic [DATA_W-1:0] hold_word;
  logic              hold_empty;
  logic              ws_lvl_q, ws_flag_q, bnd_pend_q, slot_ch_q;
  logic              wait_left_q, started_q, udr_q;
  logic              slot_load, load_real, load_fill, underrun;

  i2s_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sck_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .din_i (sck_i),
    .ev_o  (sck_ev)
  );

  i2s_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_ws_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .din_i (ws_i),
    .ev_o  (ws_ev)
  );

  // WS change is latched, then acted on at the next rising SCK
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_lvl_q  <= 1'b1;
      ws_flag_q <= 1'b0;
    end else begin
      if (ws_ev.rise || ws_ev.fall) begin
        ws_lvl_q  <= ws_ev.rise;
        ws_flag_q <= 1'b1;
      end else if (sck_ev.rise) begin
        ws_flag_q <= 1'b0;
      end
    end
  end

  assign slot_load = sck_ev.fall && bnd_pend_q;
  assign load_real = slot_load && !hold_empty && (!wait_left_q || !slot_ch_q);
  assign load_fill = slot_load && !load_real;
  assign underrun  = slot_load && hold_empty && started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bnd_pend_q  <= 1'b0;
      slot_ch_q   <= 1'b1;
      wait_left_q <= 1'b1;
      started_q   <= 1'b0;
    end else if (!en_i) begin
      bnd_pend_q  <= 1'b0;
      wait_left_q <= 1'b1;
      started_q   <= 1'b0;
    end else begin
      if (sck_ev.rise && ws_flag_q) begin
        bnd_pend_q <= 1'b1;
        slot_ch_q  <= ws_lvl_q;
      end else if (slot_load) begin
        bnd_pend_q <= 1'b0;
      end
      if (load_real) begin
        wait_left_q <= 1'b0;
        started_q   <= 1'b1;
      end else if (underrun) begin
        wait_left_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        udr_q <= 1'b0;
    else if (underrun)  udr_q <= 1'b1;
    else if (stat_rd_i) udr_q <= 1'b0;
  end

  i2s_tx_hold #(.DATA_W(DATA_W)) i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_en_i),
    .wdata_i(wr_data_i),
    .take_i (load_real),
    .word_o (hold_word),
    .txe_o  (hold_empty)
  );

  i2s_tx_shift #(.DATA_W(DATA_W), .FILL(FILL)) i_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (!en_i),
    .step_i     (sck_ev.fall),
    .load_real_i(load_real),
    .load_fill_i(load_fill),
    .word_i     (hold_word),
    .sd_o       (sd_o),
    .bsy_o      (bsy_o)
  );

  assign txe_o = hold_empty;
  assign udr_o = udr_q;
  assign irq_o = udr_q & err_ie_i;
endmodule

// File: rtl/i2s_tx_checker.sv
module i2s_tx_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic wr_en_i,
  input logic stat_rd_i,
  input logic txe_o,
  input logic udr_o,
  input logic bsy_o,
  input logic sd_o,
  input logic slot_load_i,
  input logic load_real_i,
  input logic underrun_i
);
  a_r2_write_clears_txe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !txe_o);

  a_r2_take_sets_txe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_real_i && !wr_en_i) |=> txe_o);

  // R5: underrun only rises at a slot start with nothing held
  a_r5_udr_at_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(udr_o) |-> $past(slot_load_i && txe_o));

  a_r6_udr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (udr_o && !stat_rd_i) |=> udr_o);

  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !underrun_i) |=> !udr_o);

  a_r9_bsy_from_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bsy_o) |-> $past(load_real_i));

  a_r10_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!bsy_o && !sd_o));
endmodule

bind i2s_slave_tx i2s_tx_checker i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .wr_en_i    (wr_en_i),
  .stat_rd_i  (stat_rd_i),
  .txe_o      (txe_o),
  .udr_o      (udr_o),
  .bsy_o      (bsy_o),
  .sd_o       (sd_o),
  .slot_load_i(slot_load),
  .load_real_i(load_real),
  .underrun_i (underrun)
);

// File: tb/test_i2s_slave_tx.sv
`timescale 1ns/1ps
module test_i2s_slave_tx;
  import i2s_tx_pkg::*;

  localparam int HP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, ie = 1'b0;
  logic        sck = 1'b1, ws = 1'b1;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wd = '0;
  logic        sd_o, txe_o, udr_o, bsy_o, irq_o;

  always #2.5 clk = ~clk;

  i2s_slave_tx #(.DATA_W(16), .SYNC_STAGES(2), .FILL(FILL_REPEAT)) i_i2s_slave_tx (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .en_i     (en),
    .err_ie_i (ie),
    .sck_i    (sck),
    .ws_i     (ws),
    .sd_o     (sd_o),
    .wr_en_i  (wr),
    .wr_data_i(wd),
    .stat_rd_i(rd),
    .txe_o    (txe_o),
    .udr_o    (udr_o),
    .bsy_o    (bsy_o),
    .irq_o    (irq_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int bit_idx = -1;
  bit skip_cur = 0;

  logic [15:0] exp_d[$];
  string       exp_t[$];
  bit          exp_s[$];

  // reference model state
  bit          m_full = 0, m_wait = 1, m_started = 0, m_udr = 0, m_bsy = 0;
  logic [15:0] m_hold = '0, m_last = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: receiver samples on rising SCK, pops one expected word per slot
  always @(posedge sck) begin
    logic [15:0] mon_sr;
    logic [15:0] d;
    string       t;
    bit          s;
    mon_sr = {mon_sr[14:0], sd_o};
    if (bit_idx == 0 && exp_d.size() > 0) begin
      d = exp_d.pop_front();
      t = exp_t.pop_front();
      s = exp_s.pop_front();
      if (!s) chk(t, {16'h0, mon_sr}, {16'h0, d});
    end
  end

  task automatic model_slot(input logic ch, output logic [15:0] e, output string tg);
    bit real_ld;
    if (!en) begin
      e = '0; m_bsy = 0; tg = "R10 disabled slot output";
      return;
    end
    real_ld = m_full && (!m_wait || ch == 1'b0);
    if (real_ld) begin
      e = m_hold; m_last = m_hold; m_full = 0; m_wait = 0; m_started = 1; m_bsy = 1;
      tg = "R4/R3 data word";
    end else begin
      e = m_last; m_bsy = 0;
      tg = (m_wait && m_full) ? "R8 held until left slot" : "R5 filler word";
      if (!m_full && m_started) begin
        m_udr = 1; m_wait = 1;
      end
    end
  endtask

  task automatic set_en(input logic v);
    en = v;
    if (!v) begin
      m_started = 0; m_wait = 1; m_last = '0; m_bsy = 0;
    end
  endtask

  task automatic run_slot(input logic ch, input logic do_wr, input logic [15:0] wdat,
                          input logic do_rd);
    logic [15:0] e;
    string       tg;
    bit          sk;
    model_slot(ch, e, tg);
    sk = skip_cur;
    skip_cur = 0;
    for (int b = 0; b < 16; b++) begin
      @(negedge clk);
      sck = 1'b0;
      if (b == 0) ws = ch;
      bit_idx = b;
      repeat (HP) @(negedge clk);
      sck = 1'b1;
      repeat (HP) @(negedge clk);
      if (b == 4) begin
        chk("R2 txe after slot start", {31'h0, txe_o}, {31'h0, !m_full});
        chk("R9 bsy during slot", {31'h0, bsy_o}, {31'h0, m_bsy});
        chk("R5 udr at slot start", {31'h0, udr_o}, {31'h0, m_udr});
        chk("R7 irq level", {31'h0, irq_o}, {31'h0, m_udr & ie});
      end
      if (b == 8 && do_wr) begin
        wr = 1'b1; wd = wdat;
        @(negedge clk);
        wr = 1'b0;
        m_full = 1; m_hold = wdat;
      end
      if (b == 10 && do_rd) begin
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        m_udr = 0;
      end
      if (b == 12) begin
        chk("R2 txe after write", {31'h0, txe_o}, {31'h0, !m_full});
        chk("R9 bsy unchanged by write", {31'h0, bsy_o}, {31'h0, m_bsy});
        chk("R6 udr after read", {31'h0, udr_o}, {31'h0, m_udr});
        chk("R7 irq after read", {31'h0, irq_o}, {31'h0, m_udr & ie});
      end
      if (b == 15) begin
        exp_d.push_back(e);
        exp_t.push_back(tg);
        exp_s.push_back(sk);
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 reset txe", {31'h0, txe_o}, 32'h1);
    chk("R1 reset udr", {31'h0, udr_o}, 32'h0);
    chk("R1 reset bsy", {31'h0, bsy_o}, 32'h0);
    chk("R1 reset irq", {31'h0, irq_o}, 32'h0);
    chk("R1 reset sd", {31'h0, sd_o}, 32'h0);

    // continuous stream, first word waits for a left slot (R8)
    ie = 1'b1;
    set_en(1'b1);
    run_slot(1'b1, 1'b1, 16'hA5C3, 1'b0);
    run_slot(1'b0, 1'b1, 16'h8001, 1'b0);
    run_slot(1'b1, 1'b1, 16'h7FFE, 1'b0);
    run_slot(1'b0, 1'b1, 16'h1234, 1'b0);
    run_slot(1'b1, 1'b1, 16'hF00F, 1'b0);
    run_slot(1'b0, 1'b1, 16'h0FF0, 1'b0);
    run_slot(1'b1, 1'b0, 16'h0000, 1'b0);
    // underrun slots (R5), read clears then re-raises (R6)
    run_slot(1'b0, 1'b0, 16'h0000, 1'b0);
    run_slot(1'b1, 1'b0, 16'h0000, 1'b1);
    run_slot(1'b0, 1'b0, 16'h0000, 1'b0);
    // write in a left slot: next right slot must not load it (R8)
    run_slot(1'b1, 1'b0, 16'h0000, 1'b1);
    run_slot(1'b0, 1'b1, 16'hC0DE, 1'b1);
    run_slot(1'b1, 1'b0, 16'h0000, 1'b0);
    run_slot(1'b0, 1'b1, 16'hBEEF, 1'b1);
    run_slot(1'b1, 1'b1, 16'h5A5A, 1'b0);
    run_slot(1'b0, 1'b0, 16'h0000, 1'b0);
    run_slot(1'b1, 1'b0, 16'h0000, 1'b0);
    // interrupt masked (R7)
    ie = 1'b0;
    run_slot(1'b0, 1'b0, 16'h0000, 1'b0);
    run_slot(1'b1, 1'b0, 16'h0000, 1'b1);
    ie = 1'b1;
    // disable: outputs quiet, write held while off (R10)
    skip_cur = 1;
    run_slot(1'b0, 1'b0, 16'h0000, 1'b1);
    set_en(1'b0);
    run_slot(1'b1, 1'b1, 16'h3C3C, 1'b0);
    run_slot(1'b0, 1'b0, 16'h0000, 1'b0);
    run_slot(1'b1, 1'b0, 16'h0000, 1'b0);
    set_en(1'b1);
    run_slot(1'b0, 1'b0, 16'h0000, 1'b0);
    run_slot(1'b1, 1'b1, 16'h9669, 1'b0);
    run_slot(1'b0, 1'b0, 16'h0000, 1'b0);
    run_slot(1'b1, 1'b0, 16'h0000, 1'b0);
    run_slot(1'b0, 1'b0, 16'h0000, 1'b0);
    chk("R10 safe to disable txe", {31'h0, txe_o}, 32'h1);
    chk("R10 safe to disable bsy", {31'h0, bsy_o}, 32'h0);
    finish_run();
  end
endmodule